// File: doc/BRIEF.md
# Prioritised Interrupt Controller Core with Claim/Complete Handshake

This block collects level-sensitive interrupt requests from up to 63 external sources and presents them to two privilege contexts of one hart: context 0 for machine mode and context 1 for supervisor mode. Each source has a programmable priority. Each context has its own enable bitmap and its own threshold, and drives a single interrupt-request line. A small 32-bit register bus gives software access to every setting and to a per-context claim/complete register.

Servicing a source takes two steps. A read of a context's claim register returns the ID of the best qualifying source and, in the same cycle, clears that source's pending bit and marks the source as in service. While it is in service, a gateway holds off any new request from that source. Software ends service by writing the same ID back to the claim register. If the line is still asserted at that point, the source becomes pending again.

The bus side is a two-state machine. `BUS_IDLE` is the state with no response outstanding. Any accepted read moves it to `BUS_RESP`. In `BUS_RESP` the response is presented for one cycle. From `BUS_RESP`, a further read stays in `BUS_RESP` and anything else returns to `BUS_IDLE`. A write never leaves or enters `BUS_RESP` on its own. Each of the NSRC gateways holds two flags, pending and in service. A claim moves a gateway from pending to in service. A complete moves it from in service to idle. An asserted line moves an idle gateway to pending.

Top module: `irq_hub_core`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, both `irq_o` bits are 0, and a claim read returns 0.
- R2: The priority of source k (1..NSRC) sits at byte address 4*k and reads back the low 3 bits written. Address 0 (source 0) always reads 0 and ignores writes. A source with priority 0 never raises an interrupt and is never claimed.
- R3: Enable bits for context c sit at byte address 0x2000 + 0x80*c + 4*(k/32), at bit k%32. Bit 0 of word 0 (source 0) and bits for IDs above NSRC read 0 and ignore writes.
- R4: The threshold of context c sits at 0x8000 + 0x1000*c and holds 3 bits. A source counts for a context only when its priority is strictly greater than that threshold. Writing 0xFFFFFFFF stores 7, which masks every source.
- R5: Among the sources that are pending, enabled and above threshold, a claim read returns the one with the highest priority. When priorities are equal, the lowest ID wins.
- R6: A read of the claim register at 0x8004 + 0x1000*c clears the pending bit of the returned source and returns 0 when nothing qualifies. `irq_o[c]` is registered: it reflects the qualifying set of the previous cycle, so it falls on the second clock edge after the claim is accepted.
- R7: A claimed source stays blocked even while its input is high, until its ID is written to a claim register. If the input is still high after that write, the source is pending again and can be claimed.
- R8: A complete write is ignored if its ID is 0, is above NSRC, is not in service, or is not enabled in the context whose claim register is written.
- R9: The two contexts have separate enables and thresholds and separate `irq_o` bits. A source claimed through one context is no longer pending for the other.
- R10: A read of an unmapped or misaligned address, or of an enable word beyond NSRC, returns 0.
- R11: `rsp_valid` is high for exactly the one cycle after each accepted read, with `rsp_rdata` valid in that cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level interrupt lines, bit k-1 is source k |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 2 | Interrupt request: bit 0 machine, bit 1 supervisor |

## Verification
The assertions take for granted that `req_valid` and `req_write` hold known values on every clock edge after reset, and that a bus request lasts exactly one cycle. The invariants tying pending, in-service, claim and complete together rely on that. The bench drives requests and source lines only on the falling edge and holds each request for one cycle. It keeps each source line stable across the claims that it checks, and it compares bus reads against expected values it worked out in advance from the register map.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NCTX   = 2;

    localparam logic [3:0] PRIO_PAGE = 4'h0;
    localparam logic [7:0] EN_PAGE   = 8'h20;
    localparam logic [2:0] CTX_PAGE  = 3'b100;

    typedef enum logic [0:0] {
        BUS_IDLE,
        BUS_RESP
    } bus_state_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_EN,
        RG_THR,
        RG_CLM
    } region_t;

endpackage

// File: rtl/irq_gate.sv
module irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pending_o,
    output logic busy_o
);

    logic pend_q;
    logic busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else if (claim_i) begin
            pend_q <= 1'b0;
            busy_q <= 1'b1;
        end else if (done_i) begin
            busy_q <= 1'b0;
        end else if (level_i && !busy_q) begin
            pend_q <= 1'b1;
        end
    end

    assign pending_o = pend_q;
    assign busy_o    = busy_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC:0]                pend_i,
    input  logic [NSRC:0]                en_i,
    input  logic [NSRC:0][PRIO_W-1:0]    prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              win_id_o,
    output logic                         irq_o
);

    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_pr;
    logic              found;
    logic              irq_q;

    always_comb begin
        best_id = '0;
        best_pr = '0;
        found   = 1'b0;
        for (int i = 0; i <= NSRC; i++) begin
            if (i != 0 && pend_i[i] && en_i[i] && (prio_i[i] > thr_i) &&
                (!found || prio_i[i] > best_pr)) begin
                found   = 1'b1;
                best_id = ID_W'(i);
                best_pr = prio_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= found;
    end

    assign win_id_o = best_id;
    assign irq_o    = irq_q;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    output logic                              rsp_valid,
    output logic [DATA_W-1:0]                 rsp_rdata,
    input  logic [NCTX-1:0][ID_W-1:0]         win_id,
    input  logic [NSRC:0]                     busy,
    output logic [NSRC:0][PRIO_W-1:0]         prio,
    output logic [NCTX-1:0][NSRC:0]           en,
    output logic [NCTX-1:0][PRIO_W-1:0]       thr,
    output logic [NSRC:0]                     claim_vec,
    output logic [NSRC:0]                     done_vec
);

    localparam int NWORDS = (NSRC + 32) / 32;

    bus_state_t state_q, state_d;
    region_t    rg;
    logic [9:0] a_idx;
    logic       a_ctx;
    logic [ID_W-1:0] a_sid;
    logic [ID_W-1:0] cid;
    logic       cmp_ok;
    logic       rd, wr;
    logic [DATA_W-1:0] rd_mux, rdata_q;

    logic [NSRC:0][PRIO_W-1:0]   prio_q;
    logic [NCTX-1:0][NSRC:0]     en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;

    assign rd = req_valid && !req_write;
    assign wr = req_valid && req_write;

    // address decode
    always_comb begin
        rg    = RG_NONE;
        a_ctx = 1'b0;
        a_idx = '0;
        if (req_addr[1:0] != 2'b00) begin
            rg = RG_NONE;
        end else if (req_addr[15:12] == PRIO_PAGE) begin
            a_idx = req_addr[11:2];
            if (a_idx != 10'd0 && a_idx <= 10'(NSRC)) rg = RG_PRIO;
        end else if (req_addr[15:8] == EN_PAGE) begin
            a_ctx = req_addr[7];
            a_idx = {5'd0, req_addr[6:2]};
            if (a_idx < 10'(NWORDS)) rg = RG_EN;
        end else if (req_addr[15:13] == CTX_PAGE) begin
            a_ctx = req_addr[12];
            if (req_addr[11:2] == 10'd0)      rg = RG_THR;
            else if (req_addr[11:2] == 10'd1) rg = RG_CLM;
        end
    end

    assign a_sid  = a_idx[ID_W-1:0];
    assign cid    = req_wdata[ID_W-1:0];
    assign cmp_ok = (req_wdata != '0) && (req_wdata <= DATA_W'(NSRC));

    // read data mux
    always_comb begin
        rd_mux = '0;
        unique case (rg)
            RG_PRIO: rd_mux = DATA_W'(prio_q[a_sid]);
            RG_EN: begin
                for (int b = 0; b < 32; b++) begin
                    if (int'(a_idx) * 32 + b >= 1 && int'(a_idx) * 32 + b <= NSRC)
                        rd_mux[b] = en_q[a_ctx][int'(a_idx) * 32 + b];
                end
            end
            RG_THR:  rd_mux = DATA_W'(thr_q[a_ctx]);
            RG_CLM:  rd_mux = DATA_W'(win_id[a_ctx]);
            default: rd_mux = '0;
        endcase
    end

    // claim and complete strobes
    always_comb begin
        claim_vec = '0;
        done_vec  = '0;
        if (rd && rg == RG_CLM && win_id[a_ctx] != '0)
            claim_vec[win_id[a_ctx]] = 1'b1;
        if (wr && rg == RG_CLM && cmp_ok && busy[cid] && en_q[a_ctx][cid])
            done_vec[cid] = 1'b1;
    end

    // configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (wr) begin
            unique case (rg)
                RG_PRIO: prio_q[a_sid] <= req_wdata[PRIO_W-1:0];
                RG_EN: begin
                    for (int b = 0; b < 32; b++) begin
                        if (int'(a_idx) * 32 + b >= 1 && int'(a_idx) * 32 + b <= NSRC)
                            en_q[a_ctx][int'(a_idx) * 32 + b] <= req_wdata[b];
                    end
                end
                RG_THR:  thr_q[a_ctx] <= req_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // bus response state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd) rdata_q <= rd_mux;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            BUS_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            default: ;
        endcase
    end

    assign prio = prio_q;
    assign en   = en_q;
    assign thr  = thr_q;

endmodule

// File: rtl/irq_hub_core.sv
module irq_hub_core
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC:1]        src_i,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NCTX-1:0]      irq_o
);

    localparam int ID_W = $clog2(NSRC + 1);

    logic [NSRC:0]                pending_v;
    logic [NSRC:0]                busy_v;
    logic [NSRC:0]                claim_v;
    logic [NSRC:0]                done_v;
    logic [NSRC:0][PRIO_W-1:0]    prio_v;
    logic [NCTX-1:0][NSRC:0]      en_v;
    logic [NCTX-1:0][PRIO_W-1:0]  thr_v;
    logic [NCTX-1:0][ID_W-1:0]    win_v;
    logic                         unused_id0;

    assign pending_v[0] = 1'b0;
    assign busy_v[0]    = 1'b0;
    assign unused_id0   = claim_v[0] ^ done_v[0];

    for (genvar k = 1; k <= NSRC; k++) begin : g_gate
        irq_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_i   (src_i[k]),
            .claim_i   (claim_v[k]),
            .done_i    (done_v[k]),
            .pending_o (pending_v[k]),
            .busy_o    (busy_v[k])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irq_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend_i   (pending_v),
            .en_i     (en_v[c]),
            .prio_i   (prio_v),
            .thr_i    (thr_v[c]),
            .win_id_o (win_v[c]),
            .irq_o    (irq_o[c])
        );
    end

    irq_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .win_id    (win_v),
        .busy      (busy_v),
        .prio      (prio_v),
        .en        (en_v),
        .thr       (thr_v),
        .claim_vec (claim_v),
        .done_vec  (done_v)
    );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int NSRC = 31
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic [1:0]           irq_o,
    input logic [NSRC:0]        pending_v,
    input logic [NSRC:0]        busy_v,
    input logic [NSRC:0]        claim_v,
    input logic [NSRC:0]        done_v,
    input logic [1:0][NSRC:0]   en_v
);

    a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    a_r7_no_pend_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_v & busy_v) == '0);

    a_r6_claim_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|claim_v) |=> ((busy_v & $past(claim_v)) == $past(claim_v)));

    a_r8_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_v) |-> ((done_v & busy_v) == done_v));

    a_r4_irq0_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] |-> $past(|(pending_v & en_v[0])));

    a_r9_irq1_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] |-> $past(|(pending_v & en_v[1])));

endmodule

bind irq_hub_core irq_hub_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .irq_o     (irq_o),
    .pending_v (pending_v),
    .busy_v    (busy_v),
    .claim_v   (claim_v),
    .done_v    (done_v),
    .en_v      (en_v)
);

// File: tb/irq_hub_core_tb.sv
module irq_hub_core_tb_top;

    localparam int NSRC = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC:1] src_i = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_hub_core #(.NSRC(NSRC), .PRIO_W(3)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [15:0] a_prio(input int id);
        return 16'(4 * id);
    endfunction
    function automatic logic [15:0] a_en(input int c, input int w);
        return 16'(32'h2000 + 32'h80 * c + 4 * w);
    endfunction
    function automatic logic [15:0] a_thr(input int c);
        return 16'(32'h8000 + 32'h1000 * c);
    endfunction
    function automatic logic [15:0] a_clm(input int c);
        return 16'(32'h8004 + 32'h1000 * c);
    endfunction

    // monitor: pop expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected response: actual %h expected none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [1:0] e, input string t);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk_irq(2'b00, "R1 reset irq");
        rd(a_clm(0), 32'h0, "R1 reset claim");
        rd(a_prio(5), 32'h0, "R1 reset priority");
        rd(a_thr(1), 32'h0, "R1 reset threshold");

        // R2 priority map
        wr(a_prio(3), 32'h5);
        wr(a_prio(5), 32'h1F);
        wr(a_prio(7), 32'h7);
        rd(a_prio(3), 32'h5, "R2 priority 3");
        rd(a_prio(5), 32'h7, "R2 priority truncated");
        wr(16'h0000, 32'h7);
        rd(16'h0000, 32'h0, "R2 source 0 priority");

        // R3 enable map, R10 unmapped
        wr(a_en(0, 0), 32'hFFFF_FFFF);
        rd(a_en(0, 0), 32'hFFFF_FFFE, "R3 enable bit 0 fixed");
        wr(a_en(0, 0), 32'h0000_00A8);
        rd(a_en(0, 0), 32'h0000_00A8, "R3 enable readback");
        rd(a_en(0, 1), 32'h0, "R10 enable word beyond NSRC");
        rd(16'h4000, 32'h0, "R10 unmapped");
        rd(16'h8008, 32'h0, "R10 unmapped context word");
        rd(16'h0006, 32'h0, "R10 misaligned");

        // R4 threshold
        src_i[3] = 1'b1;
        idle(3);
        chk_irq(2'b01, "R4/R9 above threshold only machine");
        wr(a_thr(0), 32'h5);
        idle(2);
        chk_irq(2'b00, "R4 equal is not above");
        wr(a_thr(0), 32'h4);
        idle(2);
        chk_irq(2'b01, "R4 strictly above");
        wr(a_thr(0), 32'hFFFF_FFFF);
        idle(2);
        chk_irq(2'b00, "R4 all ones masks");
        rd(a_thr(0), 32'h7, "R4 all ones reads 7");

        // R5 priority order and tie break, R6 empty claim
        wr(a_thr(0), 32'h0);
        src_i[5] = 1'b1;
        src_i[7] = 1'b1;
        idle(3);
        rd(a_clm(0), 32'd5, "R5 tie lowest id");
        rd(a_clm(0), 32'd7, "R5 next equal priority");
        rd(a_clm(0), 32'd3, "R5 lower priority last");
        rd(a_clm(0), 32'd0, "R6 none left");
        idle(2);
        chk_irq(2'b00, "R6 irq low after claims");

        // R7 gateway blocks until complete
        idle(5);
        rd(a_clm(0), 32'd0, "R7 claimed sources blocked");
        wr(a_clm(0), 32'd5);
        idle(3);
        rd(a_clm(0), 32'd5, "R7 pending again after complete");

        // R8 ignored completions
        wr(a_clm(0), 32'd9);
        wr(a_clm(0), 32'd40);
        wr(a_en(1, 0), 32'h0000_0008);
        wr(a_clm(1), 32'd7);
        idle(3);
        rd(a_clm(0), 32'd0, "R8 complete not enabled in context ignored");
        wr(a_clm(0), 32'd7);
        idle(3);
        rd(a_clm(0), 32'd7, "R8 valid complete accepted");

        // R9 two contexts
        wr(a_thr(1), 32'h0);
        wr(a_clm(1), 32'd3);
        idle(3);
        chk_irq(2'b11, "R9 both contexts see source 3");
        rd(a_clm(1), 32'd3, "R9 supervisor claim");
        idle(2);
        chk_irq(2'b00, "R9 claim hides source from other context");
        rd(a_clm(0), 32'd0, "R9 machine claim empty");

        // R6 exact timing of irq fall
        src_i[3] = 1'b0;
        src_i[5] = 1'b0;
        src_i[7] = 1'b0;
        wr(a_clm(0), 32'd5);
        wr(a_clm(0), 32'd7);
        wr(a_clm(1), 32'd3);
        idle(3);
        chk_irq(2'b00, "R6 quiet");
        wr(a_prio(9), 32'h2);
        wr(a_en(0, 0), 32'h0000_02A8);
        src_i[9] = 1'b1;
        idle(3);
        chk_irq(2'b01, "R6 before claim");
        rd(a_clm(0), 32'd9, "R6 claim source 9");
        chk_irq(2'b01, "R6 irq one edge after claim");
        idle(1);
        chk_irq(2'b00, "R6 irq two edges after claim");

        // R2 priority zero disables
        wr(a_en(0, 0), 32'h0000_0AA8);
        src_i[11] = 1'b1;
        idle(3);
        chk_irq(2'b00, "R2 priority 0 no irq");
        rd(a_clm(0), 32'd0, "R2 priority 0 never claimed");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 missing responses: actual %0d pending expected 0", exp_q.size());
        end

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule